// File: doc/BRIEF.md
# Coalescing Completion-Ring Writer

This block sits between a receive DMA engine and a circular completion ring in host memory. The DMA hands it one-word completion descriptors. The block holds them in a small on-chip queue and hands them to the ring in bursts. A burst leaves as a run of consecutive data beats, announced by a start index and a length. After the last beat the ring write index moves forward and a one-cycle completion pulse is raised.

When coalescing is on, a flush waits until enough descriptors have gathered. A countdown timer still forces a flush under light traffic. When coalescing is off, every descriptor goes out as soon as it arrives. In both modes the burst is trimmed to the free room in the ring, which is computed from the host's read index. One slot of the ring always stays empty. If there is no room at all, nothing is written and an error pulse is raised instead.

Top module: `cq_burst_writer`

## Requirements
- R1: After reset, `wr_idx` is 0, `push_ready` is 1, and `beat_valid`, `burst_start`, `done_pulse` and `err_pulse` are all 0.
- R2: With `coalesce_en`=1 and no timeout pending, no burst is issued while the queue holds fewer than 6 descriptors (the watermark).
- R3: Once a flush starts, the burst carries every descriptor held at the decision cycle, limited only by R4. `burst_base` equals the current `wr_idx`, and the beats on `beat_data` come out in push order.
- R4: The burst length is min(occupancy, free), where free = (host_rd_idx − wr_idx − 1) mod `ring_size`.
- R5: When a flush is due and free is 0, no beat is issued, `wr_idx` holds its value, and `err_pulse` is 1 in the cycle after each such cycle.
- R6: In the cycle after the last beat of a burst, `wr_idx` becomes (old + length) mod `ring_size` and `done_pulse` is 1 for exactly that cycle. `wr_idx` changes at no other time.
- R7: With `coalesce_en`=0, each descriptor is written as a burst of length 1 as soon as it is held.
- R8: `push_ready` is 0 while a burst is in progress and while the queue holds 8 descriptors.
- R9: With `coalesce_en`=1 and a nonzero `timer_reload` R, held descriptors are flushed about R×256 cycles after coalescing is enabled or after the last burst. A value of 0 turns this timeout flush off.
- R10: Descriptors left over from a trimmed burst, or pushed during a flush decision, stay in the queue in order and go out in a later burst.
- R11: A burst is `burst_len` back-to-back cycles with `beat_valid`=1. `burst_start` is 1 only on the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Descriptor offered |
| push_data | input | 32 | Descriptor word |
| push_ready | output | 1 | Descriptor accepted on this edge if valid |
| coalesce_en | input | 1 | 1: watermark/timeout flushing; 0: write each descriptor at once |
| ring_size | input | 10 | Number of ring slots |
| host_rd_idx | input | 10 | Host's ring read index |
| timer_reload | input | 16 | Timeout reload in units of 256 cycles; 0 turns the timeout off |
| burst_start | output | 1 | First beat of a burst |
| burst_base | output | 10 | Ring index of the first beat |
| burst_len | output | 4 | Number of beats in the burst |
| beat_valid | output | 1 | Data beat present |
| beat_data | output | 32 | Descriptor word for this beat |
| wr_idx | output | 10 | Ring write index |
| done_pulse | output | 1 | Burst written and index advanced |
| err_pulse | output | 1 | Flush due but ring has no free slot |

## Verification
Two things can happen in the same cycle: a push can be accepted in the very cycle the block decides to flush. The bench provokes this by pushing descriptors back to back past the watermark. The sixth push raises the flush, and the seventh is offered while the block is still idle, so it is accepted on the deciding edge. The bench judges the outcome from the beats: exactly six beats must leave, in push order, and the late descriptor must come out first in the next burst.

// File: rtl/cqw_pkg.sv
package cqw_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } cqw_state_e;
endpackage

// File: rtl/cqw_fifo.sv
module cqw_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    wp_n  = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    rp_n  = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    cnt_n = push ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push)        wp_q  <= wp_n;
      if (pop)         rp_q  <= rp_n;
      if (push ^ pop)  cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= wdata;
  end

  assign rdata = mem_q[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/cqw_flush_timer.sv
module cqw_flush_timer #(
  parameter int TMR_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic [TMR_W-1:0] reload_val,
  output logic             expired
);
  logic [PRE_W-1:0] pre_q, pre_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic             hold, tick, tmr_ld;

  always_comb begin
    hold   = !enable || restart;
    tick   = &pre_q;
    pre_n  = hold ? '0 : pre_q + 1'b1;
    tmr_n  = hold ? reload_val : tmr_q - 1'b1;
    tmr_ld = hold || (tick && (tmr_q != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else begin
      pre_q <= pre_n;
      if (tmr_ld) tmr_q <= tmr_n;
    end
  end

  assign expired = enable && (reload_val != '0) && (tmr_q == '0);
endmodule

// File: rtl/cqw_ring_space.sv
module cqw_ring_space #(
  parameter int IDX_W = 10,
  parameter int LEN_W = 4
) (
  input  logic [IDX_W-1:0] ring_size,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] cur_wr,
  input  logic [LEN_W-1:0] occupancy,
  input  logic [LEN_W-1:0] adv_len,
  output logic [LEN_W-1:0] grant_len,
  output logic [IDX_W-1:0] wr_after
);
  localparam int W = IDX_W + 1;

  logic [W-1:0] size_w, room_raw, room, occ_w, sum;

  always_comb begin
    size_w   = {1'b0, ring_size};
    room_raw = {1'b0, rd_idx} + size_w - {1'b0, cur_wr} - W'(1);
    room     = (room_raw >= size_w) ? room_raw - size_w : room_raw;
    occ_w    = {{(W-LEN_W){1'b0}}, occupancy};
    grant_len = (room < occ_w) ? room[LEN_W-1:0] : occupancy;
    sum      = {1'b0, cur_wr} + {{(W-LEN_W){1'b0}}, adv_len};
    if (sum >= size_w) sum = sum - size_w;
    wr_after = sum[IDX_W-1:0];
  end
endmodule

// File: rtl/cq_burst_writer.sv
module cq_burst_writer #(
  parameter int DESC_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int HIGH_WM    = 6,
  parameter int IDX_W      = 10,
  parameter int TMR_W      = 16,
  parameter int PRE_W      = 8,
  parameter int LEN_W      = $clog2(FIFO_DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DESC_W-1:0] push_data,
  output logic              push_ready,
  input  logic              coalesce_en,
  input  logic [IDX_W-1:0]  ring_size,
  input  logic [IDX_W-1:0]  host_rd_idx,
  input  logic [TMR_W-1:0]  timer_reload,
  output logic              burst_start,
  output logic [IDX_W-1:0]  burst_base,
  output logic [LEN_W-1:0]  burst_len,
  output logic              beat_valid,
  output logic [DESC_W-1:0] beat_data,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              done_pulse,
  output logic              err_pulse
);
  import cqw_pkg::*;

  localparam logic [LEN_W-1:0] WM_L = LEN_W'(HIGH_WM);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta_q, rs_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end

  cqw_state_e       state_q, state_n;
  logic [IDX_W-1:0] base_q, base_n, wr_q, wr_n;
  logic [LEN_W-1:0] len_q, len_n, beat_q, beat_n;
  logic             done_q, done_n, err_q, err_n;
  logic             ld_burst, ld_wr, ld_beat;

  logic              q_push, q_pop, q_full, q_empty;
  logic [LEN_W-1:0]  q_count, grant, adv_len;
  logic [DESC_W-1:0] q_rdata;
  logic [IDX_W-1:0]  wr_adv;
  logic              tmr_expired, tmr_restart, flush_due, last_beat;

  cqw_fifo #(.DW(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rs_sync_q), .push(q_push), .wdata(push_data),
    .pop(q_pop), .rdata(q_rdata), .count(q_count), .full(q_full),
    .empty(q_empty)
  );

  cqw_flush_timer #(.TMR_W(TMR_W), .PRE_W(PRE_W)) u_timer (
    .clk(clk), .rst_n(rs_sync_q), .enable(coalesce_en),
    .restart(tmr_restart), .reload_val(timer_reload), .expired(tmr_expired)
  );

  cqw_ring_space #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_space (
    .ring_size(ring_size), .rd_idx(host_rd_idx), .cur_wr(wr_q),
    .occupancy(q_count), .adv_len(adv_len), .grant_len(grant),
    .wr_after(wr_adv)
  );

  assign adv_len    = len_q;
  assign push_ready = (state_q == ST_IDLE) && !q_full;
  assign q_push     = push_valid && push_ready;
  assign q_pop      = (state_q == ST_BURST);
  assign last_beat  = (state_q == ST_BURST) && (beat_q == len_q - 1'b1);
  assign tmr_restart = last_beat;

  always_comb begin
    if (coalesce_en) flush_due = (q_count >= WM_L) || (tmr_expired && !q_empty);
    else             flush_due = !q_empty;
  end

  // next-state logic
  always_comb begin
    state_n  = state_q;
    base_n   = wr_q;
    len_n    = grant;
    beat_n   = beat_q + 1'b1;
    wr_n     = wr_adv;
    done_n   = 1'b0;
    err_n    = 1'b0;
    ld_burst = 1'b0;
    ld_wr    = 1'b0;
    ld_beat  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (flush_due) begin
          if (grant == '0) begin
            err_n = 1'b1;
          end else begin
            state_n  = ST_BURST;
            ld_burst = 1'b1;
            ld_beat  = 1'b1;
            beat_n   = '0;
          end
        end
      end
      ST_BURST: begin
        ld_beat = 1'b1;
        if (last_beat) begin
          state_n = ST_IDLE;
          ld_wr   = 1'b1;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rs_sync_q) begin
    if (!rs_sync_q) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      len_q   <= '0;
      beat_q  <= '0;
      wr_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      err_q   <= err_n;
      if (ld_burst) begin
        base_q <= base_n;
        len_q  <= len_n;
      end
      if (ld_beat) beat_q <= beat_n;
      if (ld_wr)   wr_q   <= wr_n;
    end
  end

  assign beat_valid  = (state_q == ST_BURST);
  assign burst_start = beat_valid && (beat_q == '0);
  assign burst_base  = base_q;
  assign burst_len   = len_q;
  assign beat_data   = q_rdata;
  assign wr_idx      = wr_q;
  assign done_pulse  = done_q;
  assign err_pulse   = err_q;
endmodule

// File: rtl/cqw_checker.sv
module cqw_checker #(
  parameter int IDX_W = 10,
  parameter int LEN_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_ready,
  input logic             beat_valid,
  input logic             burst_start,
  input logic [LEN_W-1:0] burst_len,
  input logic [IDX_W-1:0] wr_idx,
  input logic             done_pulse,
  input logic             err_pulse
);
  // R8
  push_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !push_ready);

  // R5
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (!beat_valid && !done_pulse));

  // R6
  done_after_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($past(beat_valid) && !beat_valid));

  // R6
  idx_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |-> $stable(wr_idx));

  // R11
  beats_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !burst_start) |-> $past(beat_valid));

  // R4
  len_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> (burst_len != '0 && burst_len <= LEN_W'(DEPTH)));
endmodule

bind cq_burst_writer cqw_checker #(.IDX_W(IDX_W), .LEN_W(LEN_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rs_sync_q), .push_ready(push_ready), .beat_valid(beat_valid),
  .burst_start(burst_start), .burst_len(burst_len), .wr_idx(wr_idx),
  .done_pulse(done_pulse), .err_pulse(err_pulse)
);

// File: tb/cq_burst_writer_test.sv
module cq_burst_writer_test;
  localparam logic [31:0] DBASE = 32'hA500_0000;

  typedef struct packed {
    logic       en;
    logic [9:0] size;
    logic [9:0] rd;
    logic [4:0] npush;
    logic [4:0] beats;
    logic [3:0] bursts;
    logic       err;
    logic [9:0] wr;
  } vec_t;

  // size, en, rd, pushes -> beats, bursts, error seen, final wr_idx
  localparam vec_t VECS [9] = '{
    '{1'b0, 10'd16, 10'd0, 5'd3,  5'd3,  4'd3, 1'b0, 10'd3},   // R7 singles
    '{1'b1, 10'd16, 10'd0, 5'd5,  5'd0,  4'd0, 1'b0, 10'd0},   // R2 below mark
    '{1'b1, 10'd16, 10'd0, 5'd6,  5'd6,  4'd1, 1'b0, 10'd6},   // R3 at mark
    '{1'b1, 10'd16, 10'd0, 5'd8,  5'd6,  4'd1, 1'b0, 10'd6},   // R10 push on decision
    '{1'b1, 10'd16, 10'd4, 5'd6,  5'd3,  4'd1, 1'b0, 10'd3},   // R4 trimmed
    '{1'b1, 10'd16, 10'd1, 5'd6,  5'd0,  4'd0, 1'b1, 10'd0},   // R5 no room
    '{1'b0, 10'd16, 10'd2, 5'd2,  5'd1,  4'd1, 1'b1, 10'd1},   // R5 fills then error
    '{1'b1, 10'd16, 10'd0, 5'd12, 5'd12, 4'd2, 1'b0, 10'd12},  // R10 leftovers
    '{1'b1, 10'd4,  10'd0, 5'd6,  5'd3,  4'd1, 1'b0, 10'd3}    // R4 small ring
  };

  logic        clk, rst_n;
  logic        push_valid, push_ready, coalesce_en;
  logic [31:0] push_data, beat_data;
  logic [9:0]  ring_size, host_rd_idx, burst_base, wr_idx;
  logic [15:0] timer_reload;
  logic [3:0]  burst_len;
  logic        burst_start, beat_valid, done_pulse, err_pulse;

  cq_burst_writer uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .coalesce_en(coalesce_en), .ring_size(ring_size),
    .host_rd_idx(host_rd_idx), .timer_reload(timer_reload),
    .burst_start(burst_start), .burst_base(burst_base), .burst_len(burst_len),
    .beat_valid(beat_valid), .beat_data(beat_data), .wr_idx(wr_idx),
    .done_pulse(done_pulse), .err_pulse(err_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_checks, n_fail, seq;
  int m_beats, m_bursts, m_done, m_err, m_mism, m_maxlen;
  logic [9:0] m_base;
  longint cyc;

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_beats = 0; m_bursts = 0; m_done = 0; m_err = 0; m_mism = 0; m_maxlen = 0;
      m_base = '0;
    end else begin
      if (beat_valid) begin
        if (beat_data !== DBASE + 32'(m_beats)) m_mism = m_mism + 1;
        m_beats = m_beats + 1;
      end
      if (burst_start) begin
        m_bursts = m_bursts + 1;
        m_base = burst_base;
        if (int'(burst_len) > m_maxlen) m_maxlen = int'(burst_len);
      end
      if (done_pulse) m_done = m_done + 1;
      if (err_pulse)  m_err  = m_err + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic en, input logic [9:0] sz, input logic [9:0] rd,
                          input logic [15:0] rl);
    @(negedge clk);
    rst_n = 1'b0; push_valid = 1'b0; push_data = '0;
    coalesce_en = en; ring_size = sz; host_rd_idx = rd; timer_reload = rl;
    seq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic push_n(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (push_ready) begin
        push_valid = 1'b1; push_data = DBASE + 32'(seq); seq++; k++;
      end else push_valid = 1'b0;
    end
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  initial begin
    cyc = 0; n_checks = 0; n_fail = 0;
    rst_n = 1'b0; push_valid = 1'b0; push_data = '0; coalesce_en = 1'b0;
    ring_size = 10'd16; host_rd_idx = '0; timer_reload = '0;

    // R1 reset state
    do_reset(1'b0, 10'd16, 10'd0, 16'd0);
    check(wr_idx == 0, "R1 wr_idx", wr_idx, 0);
    check(push_ready == 1'b1, "R1 push_ready", push_ready, 1);
    check({beat_valid, burst_start, done_pulse, err_pulse} == 4'b0, "R1 outputs idle",
          {beat_valid, burst_start, done_pulse, err_pulse}, 0);

    // vector table
    for (int i = 0; i < 9; i++) begin
      do_reset(VECS[i].en, VECS[i].size, VECS[i].rd, 16'd0);
      push_n(int'(VECS[i].npush));
      repeat (40) @(negedge clk);
      check(m_beats == int'(VECS[i].beats), $sformatf("R3/R4 vec%0d beats", i), m_beats, VECS[i].beats);
      check(m_bursts == int'(VECS[i].bursts), $sformatf("R2/R11 vec%0d bursts", i), m_bursts, VECS[i].bursts);
      check(m_done == m_bursts, $sformatf("R6 vec%0d done count", i), m_done, m_bursts);
      check((m_err != 0) == VECS[i].err, $sformatf("R5 vec%0d error seen", i), m_err != 0, VECS[i].err);
      check(wr_idx == VECS[i].wr, $sformatf("R6 vec%0d wr_idx", i), wr_idx, VECS[i].wr);
      check(m_mism == 0, $sformatf("R3/R10 vec%0d order", i), m_mism, 0);
      if (!VECS[i].en && m_bursts != 0)
        check(m_maxlen == 1, $sformatf("R7 vec%0d burst length", i), m_maxlen, 1);
    end

    // R8 full queue, then R5 error released by host read index
    do_reset(1'b1, 10'd16, 10'd1, 16'd0);
    push_n(8);
    @(negedge clk);
    check(push_ready == 1'b0, "R8 ready low when full", push_ready, 0);
    check(m_err != 0 && m_beats == 0, "R5 error while ring full", m_err, 1);
    check(wr_idx == 0, "R5 wr_idx held", wr_idx, 0);
    host_rd_idx = 10'd0;
    repeat (20) @(negedge clk);
    check(m_beats == 8, "R3 full drain beats", m_beats, 8);
    check(wr_idx == 8, "R6 wr_idx after drain", wr_idx, 8);

    // R6 wrap of the write index
    do_reset(1'b0, 10'd4, 10'd0, 16'd0);
    push_n(3);
    repeat (10) @(negedge clk);
    check(wr_idx == 3 && m_err == 0, "R6 wr_idx before wrap", wr_idx, 3);
    host_rd_idx = 10'd3;
    push_n(2);
    repeat (10) @(negedge clk);
    check(wr_idx == 1, "R6 wr_idx wrapped", wr_idx, 1);
    check(m_base == 0, "R3 burst_base after wrap", m_base, 0);
    check(m_beats == 5 && m_mism == 0, "R6 beats across wrap", m_beats, 5);

    // R9 timeout flush and reload
    do_reset(1'b0, 10'd16, 10'd0, 16'd3);
    coalesce_en = 1'b1;
    push_n(1);
    repeat (500) @(negedge clk);
    check(m_beats == 0, "R9 no flush before timeout", m_beats, 0);
    repeat (400) @(negedge clk);
    check(m_beats == 1 && wr_idx == 1, "R9 flush on timeout", m_beats, 1);
    push_n(1);
    repeat (500) @(negedge clk);
    check(m_beats == 1, "R9 timer reloaded by burst", m_beats, 1);
    repeat (400) @(negedge clk);
    check(m_beats == 2 && m_done == 2, "R9 second timeout flush", m_beats, 2);

    // R9 reload of zero: no timeout
    do_reset(1'b1, 10'd16, 10'd0, 16'd0);
    push_n(1);
    repeat (1200) @(negedge clk);
    check(m_beats == 0 && m_err == 0, "R9 zero reload never flushes", m_beats, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule